// File: doc/BRIEF.md
# Mode-Configurable Asynchronous Serial Transmitter

This block turns bytes into an asynchronous serial frame on a single transmit line. The frame format comes from a set of mode fields that can change at run time: how many transmit-clock periods make up one bit cell (1, 16 or 64), how many data bits a character carries (5 to 8), whether a parity bit is added and what sense it has, and whether the stop period is one, one and a half or two cells long. The block runs entirely on the transmit clock. Producing that clock from a system clock is left to the surrounding logic.

A host writes a byte into a one-entry holding buffer with a single-cycle strobe. The character moves into the frame sequencer once the sequencer is free and transmission is enabled. Each frame is a low start cell, then the data bits least significant first, then an optional parity bit, then a high stop period. Between frames the line is high. The mode fields are sampled at the moment a character starts, so they may change while it is being sent. A break request forces the line low for as long as it is held, and frame timing keeps running underneath it. Two flags report the state of the block: one says the holding buffer can take a byte, and the other says that nothing is buffered and nothing is being sent.

Top module: `async_tx_fmt`

## Requirements
- R1: After reset, `txd` is high, `buf_ready` is high and `shift_empty` is high.
- R2: A bit cell lasts 1 clock when `clk_fac` is 00 or 01, 16 clocks when it is 10, and 64 clocks when it is 11.
- R3: A frame begins with one low start cell. The data bits follow, least significant first, and their number is 5, 6, 7 or 8 for `chr_len` 00, 01, 10 or 11. Bits of `wr_data` above that length have no effect on the line.
- R4: With `par_en`=1, a single parity cell comes right after the data. Its value is the XOR of the sent data bits when `par_even`=1 and the complement of that XOR when `par_even`=0. With `par_en`=0 no parity cell is sent.
- R5: The stop period is high. It lasts one cell for `stop_sel` 00 or 01, two cells for 11, and for 10 it lasts 2 clocks at 1x, 24 clocks at 16x and 96 clocks at 64x. The line is also high when idle.
- R6: While `brk` is 1, `txd` is 0, and the frame in progress keeps its timing.
- R7: No character starts while `tx_en` is 0. A frame already in progress runs to its end.
- R8: The holding buffer stores one byte. `buf_ready` is high exactly when the buffer is empty. A `wr_stb` while `buf_ready` is high captures `wr_data`, and a `wr_stb` while it is low is dropped.
- R9: `shift_empty` is high only when the buffer is empty and no frame is in progress.
- R10: If a character is waiting in the buffer and `tx_en` is 1, its start cell begins on the clock right after the last stop clock of the previous frame. Mode fields are sampled at that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_fac | input | 2 | Clock periods per bit cell select |
| chr_len | input | 2 | Data bit count select (5 + value) |
| par_en | input | 1 | Add a parity cell |
| par_even | input | 1 | Parity sense: 1 even, 0 odd |
| stop_sel | input | 2 | Stop period length select |
| tx_en | input | 1 | Allow new characters to start |
| brk | input | 1 | Force the line low |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial line, idle high |
| buf_ready | output | 1 | Holding buffer can accept a byte |
| shift_empty | output | 1 | Buffer empty and no frame in progress |

## Verification
A wrong cell counter shows up at the very next bit boundary as an edge on `txd` that comes early or late. A cell in error for 64x can take 64 clocks to show, and a wrong stop length shows only at the next start or when `shift_empty` rises. A wrong bit index or shift state changes the data or parity level inside the same frame. A fault in the buffer flag shows at the ports within one clock, as a wrong `buf_ready`, a dropped character or a repeated one. The reference model predicts the line level, both flags and the break override on every clock, so any of these faults is seen in the first cycle where it changes a port.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  localparam int CHAR_MAX = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } tx_phase_t;

  // clocks per bit cell from the factor field
  function automatic int cell_clocks(input logic [1:0] fac, input int mid, input int hi);
    case (fac)
      2'b10:   return mid;
      2'b11:   return hi;
      default: return 1;
    endcase
  endfunction

  // clocks of the stop period; 1.5 cells rounds up to 2 in 1x
  function automatic int stop_clocks(input logic [1:0] fac, input logic [1:0] stop,
                                     input int mid, input int hi);
    int c;
    c = cell_clocks(fac, mid, hi);
    case (stop)
      2'b10:   return (c == 1) ? 2 : (c * 3) / 2;
      2'b11:   return 2 * c;
      default: return c;
    endcase
  endfunction

  function automatic int data_bits(input logic [1:0] len);
    return 5 + int'(len);
  endfunction

  function automatic logic [CHAR_MAX-1:0] mask_char(input logic [CHAR_MAX-1:0] d,
                                                    input logic [1:0] len);
    logic [CHAR_MAX-1:0] m;
    for (int i = 0; i < CHAR_MAX; i++) m[i] = (i < data_bits(len));
    return d & m;
  endfunction

  function automatic logic parity_of(input logic [CHAR_MAX-1:0] d, input logic even);
    return even ? ^d : ~^d;
  endfunction

endpackage

// File: rtl/async_tx_hold.sv
module async_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr_stb && !full) begin
      full <= 1'b1;
      data <= wr_data;
    end
  end

endmodule

// File: rtl/async_tx_timer.sv
module async_tx_timer #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic [CW-1:0] reload_val,
  input  logic          run,
  output logic          cell_end
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (reload)            cnt <= reload_val;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign cell_end = run && (cnt == '0);

endmodule

// File: rtl/async_tx_seq.sv
module async_tx_seq
  import async_tx_pkg::*;
#(
  parameter int CW       = 7,
  parameter int MID_DIV  = 16,
  parameter int HIGH_DIV = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CHAR_MAX-1:0] ld_data,
  input  logic [1:0]          clk_fac,
  input  logic [1:0]          chr_len,
  input  logic                par_en,
  input  logic                par_even,
  input  logic [1:0]          stop_sel,
  input  logic                cell_end,
  output logic                line,
  output logic                busy,
  output logic                free,
  output logic                reload,
  output logic [CW-1:0]       reload_val
);

  localparam int IDX_W = $clog2(CHAR_MAX);

  tx_phase_t           phase;
  logic [CHAR_MAX-1:0] sr;
  logic [IDX_W-1:0]    bit_idx;
  logic [IDX_W-1:0]    last_idx;
  logic                has_par;
  logic                par_q;
  logic [CW-1:0]       cell_m1;
  logic [CW-1:0]       stop_m1;
  logic                last_data;

  assign busy      = (phase != PH_IDLE);
  assign free      = (phase == PH_IDLE) || (phase == PH_STOP && cell_end);
  assign last_data = (bit_idx == last_idx);

  // timer reload for the next cell
  always_comb begin
    reload     = 1'b0;
    reload_val = cell_m1;
    if (load) begin
      reload     = 1'b1;
      reload_val = CW'(cell_clocks(clk_fac, MID_DIV, HIGH_DIV) - 1);
    end else if (cell_end) begin
      case (phase)
        PH_START: reload = 1'b1;
        PH_DATA: begin
          reload = 1'b1;
          if (last_data && !has_par) reload_val = stop_m1;
        end
        PH_PAR: begin
          reload     = 1'b1;
          reload_val = stop_m1;
        end
        default: reload = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      line     <= 1'b1;
      sr       <= '0;
      bit_idx  <= '0;
      last_idx <= '0;
      has_par  <= 1'b0;
      par_q    <= 1'b0;
      cell_m1  <= '0;
      stop_m1  <= '0;
    end else if (load) begin
      phase    <= PH_START;
      line     <= 1'b0;
      sr       <= mask_char(ld_data, chr_len);
      bit_idx  <= '0;
      last_idx <= IDX_W'(data_bits(chr_len) - 1);
      has_par  <= par_en;
      par_q    <= parity_of(mask_char(ld_data, chr_len), par_even);
      cell_m1  <= CW'(cell_clocks(clk_fac, MID_DIV, HIGH_DIV) - 1);
      stop_m1  <= CW'(stop_clocks(clk_fac, stop_sel, MID_DIV, HIGH_DIV) - 1);
    end else if (cell_end) begin
      case (phase)
        PH_START: begin
          phase   <= PH_DATA;
          line    <= sr[0];
          sr      <= sr >> 1;
          bit_idx <= '0;
        end
        PH_DATA: begin
          if (last_data) begin
            if (has_par) begin
              phase <= PH_PAR;
              line  <= par_q;
            end else begin
              phase <= PH_STOP;
              line  <= 1'b1;
            end
          end else begin
            line    <= sr[0];
            sr      <= sr >> 1;
            bit_idx <= bit_idx + 1'b1;
          end
        end
        PH_PAR: begin
          phase <= PH_STOP;
          line  <= 1'b1;
        end
        PH_STOP: begin
          phase <= PH_IDLE;
          line  <= 1'b1;
        end
        default: begin
          phase <= PH_IDLE;
          line  <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/async_tx_fmt.sv
module async_tx_fmt
  import async_tx_pkg::*;
#(
  parameter int MID_DIV  = 16,
  parameter int HIGH_DIV = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          clk_fac,
  input  logic [1:0]          chr_len,
  input  logic                par_en,
  input  logic                par_even,
  input  logic [1:0]          stop_sel,
  input  logic                tx_en,
  input  logic                brk,
  input  logic                wr_stb,
  input  logic [CHAR_MAX-1:0] wr_data,
  output logic                txd,
  output logic                buf_ready,
  output logic                shift_empty
);

  localparam int CW = $clog2(2 * HIGH_DIV);

  logic                hold_full;
  logic [CHAR_MAX-1:0] hold_data;
  logic                seq_free;
  logic                seq_busy;
  logic                seq_line;
  logic                load_evt;
  logic                cell_end;
  logic                tmr_reload;
  logic [CW-1:0]       tmr_val;

  assign load_evt = seq_free && hold_full && tx_en;

  async_tx_hold #(.W(CHAR_MAX)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .take    (load_evt),
    .full    (hold_full),
    .data    (hold_data)
  );

  async_tx_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload     (tmr_reload),
    .reload_val (tmr_val),
    .run        (seq_busy),
    .cell_end   (cell_end)
  );

  async_tx_seq #(.CW(CW), .MID_DIV(MID_DIV), .HIGH_DIV(HIGH_DIV)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_evt),
    .ld_data    (hold_data),
    .clk_fac    (clk_fac),
    .chr_len    (chr_len),
    .par_en     (par_en),
    .par_even   (par_even),
    .stop_sel   (stop_sel),
    .cell_end   (cell_end),
    .line       (seq_line),
    .busy       (seq_busy),
    .free       (seq_free),
    .reload     (tmr_reload),
    .reload_val (tmr_val)
  );

  assign txd         = seq_line & ~brk;
  assign buf_ready   = ~hold_full;
  assign shift_empty = ~hold_full & ~seq_busy;

endmodule

// File: rtl/async_tx_fmt_chk.sv
module async_tx_fmt_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         brk,
  input logic         tx_en,
  input logic         txd,
  input logic         buf_ready,
  input logic         shift_empty,
  input logic         busy,
  input logic         line_q,
  input logic [W-1:0] hold_q,
  input logic         load_evt
);

  // R6
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n) brk |-> !txd);

  // R7
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy) |=> !busy);

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_ready && !load_evt) |=> $stable(hold_q));

  // R9
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> (buf_ready && line_q));

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !line_q);

  // R5
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> line_q);

  // R10
  back_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && busy) |=> (busy && !line_q));

endmodule

bind async_tx_fmt async_tx_fmt_chk #(.W(8)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .brk         (brk),
  .tx_en       (tx_en),
  .txd         (txd),
  .buf_ready   (buf_ready),
  .shift_empty (shift_empty),
  .busy        (seq_busy),
  .line_q      (seq_line),
  .hold_q      (hold_data),
  .load_evt    (load_evt)
);

// File: tb/async_tx_fmt_bench.sv
module async_tx_fmt_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] clk_fac = 2'b01;
  logic [1:0] chr_len = 2'b11;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic [1:0] stop_sel = 2'b01;
  logic       tx_en = 1'b0;
  logic       brk = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd, buf_ready, shift_empty;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  async_tx_fmt u_async_tx_fmt (
    .clk(clk), .rst_n(rst_n), .clk_fac(clk_fac), .chr_len(chr_len),
    .par_en(par_en), .par_even(par_even), .stop_sel(stop_sel),
    .tx_en(tx_en), .brk(brk), .wr_stb(wr_stb), .wr_data(wr_data),
    .txd(txd), .buf_ready(buf_ready), .shift_empty(shift_empty)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model: one queue entry per clock ----------------
  int   lvl_q[$];
  bit   m_full = 0;
  bit   m_act  = 0;
  bit   m_line = 1;
  logic [7:0] m_byte;

  function automatic int per_cell(input logic [1:0] f);
    if (f == 2'b10) return 16;
    if (f == 2'b11) return 64;
    return 1;
  endfunction

  task automatic build_frame(input logic [7:0] b);
    int f, n, ones, s;
    f = per_cell(clk_fac);
    n = 5 + int'(chr_len);
    ones = 0;
    repeat (f) lvl_q.push_back(0);
    for (int k = 0; k < n; k++) begin
      repeat (f) lvl_q.push_back(int'(b[k]));
      ones += int'(b[k]);
    end
    if (par_en) repeat (f) lvl_q.push_back(par_even ? (ones % 2) : 1 - (ones % 2));
    if (stop_sel == 2'b11)      s = 2 * f;
    else if (stop_sel == 2'b10) s = (f == 1) ? 2 : f + f / 2;
    else                        s = f;
    repeat (s) lvl_q.push_back(1);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q.delete();
      m_full = 0;
      m_act  = 0;
      m_line = 1;
    end else begin
      bit go;
      go = (lvl_q.size() == 0) && m_full && tx_en;
      if (lvl_q.size() != 0) m_line = lvl_q.pop_front() != 0;
      else if (go) begin
        build_frame(m_byte);
        m_line = lvl_q.pop_front() != 0;
        m_act  = 1;
      end else begin
        m_line = 1;
        m_act  = 0;
      end
      if (go) m_full = 0;
      else if (wr_stb && !m_full) begin
        m_full = 1;
        m_byte = wr_data;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2/R3/R4/R5/R6 txd per clock", int'(txd), brk ? 0 : int'(m_line));
      chk("R8 buf_ready per clock", int'(buf_ready), m_full ? 0 : 1);
      chk("R9 shift_empty per clock", int'(shift_empty), (!m_full && !m_act) ? 1 : 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #3;
    end
  endtask

  task automatic wr(input logic [7:0] b);
    tick(1);
    wr_stb  = 1'b1;
    wr_data = b;
    tick(1);
    wr_stb  = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] f, input logic [1:0] l, input logic pe,
                          input logic pv, input logic [1:0] s);
    clk_fac = f; chr_len = l; par_en = pe; par_even = pv; stop_sel = s;
  endtask

  task automatic wait_empty();
    int guard = 0;
    while (!shift_empty && guard < 5000) begin
      tick(1);
      guard++;
    end
  endtask

  // decode one frame from the line, sampling mid-cell
  task automatic rx_check(input logic [7:0] exp_b, input int n, input int f,
                          input bit pe, input bit pv, input string tag);
    int pos = 0, ones = 0, tgt;
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    for (int k = 0; k < n + (pe ? 1 : 0); k++) begin
      tgt = f * (k + 1) + f / 2;
      while (pos < tgt) begin
        @(negedge clk);
        pos++;
      end
      if (k < n) begin
        chk({tag, " data bit"}, int'(txd), int'(exp_b[k]));
        ones += int'(exp_b[k]);
      end else begin
        chk({tag, " R4 parity bit"}, int'(txd), pv ? ones % 2 : 1 - ones % 2);
      end
    end
  endtask

  // start-to-idle length of the second of two back-to-back all-ones frames
  task automatic measure(input int exp_len, input string tag);
    int cnt = 0;
    logic prev;
    wr(8'hFF);
    while (!buf_ready) tick(1);
    wr(8'hFF);
    @(negedge clk);
    prev = txd;
    while (!(prev == 1'b1 && txd == 1'b0)) begin
      prev = txd;
      @(negedge clk);
    end
    while (!shift_empty && cnt < 5000) begin
      @(negedge clk);
      cnt++;
    end
    chk(tag, cnt, exp_len);
    tick(1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    tick(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset txd", int'(txd), 1);
    chk("R1 reset buf_ready", int'(buf_ready), 1);
    chk("R1 reset shift_empty", int'(shift_empty), 1);

    // R7: nothing starts while disabled; R8: second write dropped
    set_mode(2'b01, 2'b11, 1'b0, 1'b0, 2'b01);
    wr(8'h5A);
    tick(40);
    chk("R7 line idle while disabled", int'(txd), 1);
    chk("R8 buffer full after write", int'(buf_ready), 0);
    chk("R9 not empty with byte held", int'(shift_empty), 0);
    wr(8'hC3);
    fork
      rx_check(8'h5A, 8, 1, 0, 0, "R3 1x 8N1");
      begin tick(2); tx_en = 1'b1; end
    join
    tick(20);
    chk("R8 dropped write sent nothing", int'(shift_empty), 1);
    chk("R8 line idle after single frame", int'(txd), 1);

    // R3/R4: 16x, 7 bits, even parity, top bit ignored
    set_mode(2'b10, 2'b10, 1'b1, 1'b1, 2'b01);
    fork
      rx_check(8'h75, 7, 16, 1, 1, "R3 16x 7E1");
      wr(8'hF5);
    join
    wait_empty();

    // R3/R4: 64x, 5 bits, odd parity, upper bits ignored
    set_mode(2'b11, 2'b00, 1'b1, 1'b0, 2'b11);
    fork
      rx_check(8'h06, 5, 64, 1, 0, "R3 64x 5O2");
      wr(8'hE6);
    join
    wait_empty();

    // R2/R5/R10: frame lengths from back-to-back starts
    set_mode(2'b01, 2'b11, 1'b0, 1'b0, 2'b10);
    measure(1 * 9 + 2, "R5 1x 8N1.5 frame length");
    set_mode(2'b00, 2'b00, 1'b0, 1'b0, 2'b00);
    measure(1 * 6 + 1, "R2 factor 00 frame length");
    set_mode(2'b10, 2'b01, 1'b1, 1'b0, 2'b10);
    measure(16 * 8 + 24, "R5 16x 6O1.5 frame length");
    set_mode(2'b11, 2'b00, 1'b0, 1'b0, 2'b11);
    measure(64 * 6 + 128, "R10 64x 5N2 frame length");
    set_mode(2'b11, 2'b11, 1'b0, 1'b0, 2'b10);
    measure(64 * 9 + 96, "R5 64x 8N1.5 frame length");
    set_mode(2'b10, 2'b11, 1'b0, 1'b0, 2'b01);
    measure(16 * 10, "R2 16x 8N1 frame length");

    // R6: break in the middle of a frame and while idle
    wr(8'hFF);
    tick(20);
    brk = 1'b1;
    tick(10);
    @(negedge clk);
    chk("R6 break holds line low in frame", int'(txd), 0);
    chk("R9 busy while frame runs", int'(shift_empty), 0);
    tick(1);
    brk = 1'b0;
    wait_empty();
    brk = 1'b1;
    tick(3);
    @(negedge clk);
    chk("R6 break holds line low when idle", int'(txd), 0);
    tick(1);
    brk = 1'b0;

    // R7: disabling mid-frame lets the frame finish, next byte waits
    set_mode(2'b01, 2'b11, 1'b0, 1'b0, 2'b01);
    wr(8'h81);
    while (!buf_ready) tick(1);
    wr(8'h42);
    tx_en = 1'b0;
    tick(30);
    chk("R7 held byte waits while disabled", int'(buf_ready), 0);
    chk("R7 line idle after frame end", int'(txd), 1);
    fork
      rx_check(8'h42, 8, 1, 0, 0, "R7 resumed frame");
      begin tick(1); tx_en = 1'b1; end
    join
    wait_empty();
    tick(5);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule